// File: doc/BRIEF.md
# Secondary Core Start Controller

This block holds the secondary processor cores of a small cluster in halt after reset and lets software release each one at an address it chooses. Core 0 is the boot core. It leaves reset already running from a fixed vector. Every other core waits in halt until software starts it.

Software drives the block through a single auxiliary-register write port that decodes two word-wide registers. The first is a parameter register. The second is a command register. Starting a core takes three writes:

1. Write the start address to the parameter register.
2. Issue a load-PC command that names the core. This copies the parameter value into that core's start-PC latch.
3. Issue a release command for the same core. This raises the core's run line and sends a one-cycle start strobe, while the start-PC bus carries the latched address.

A single parameter/command pair serves all cores. The target core is chosen by an index field inside the command word.

Top module: `core_start_ctrl`

## Requirements
- R1: After synchronous reset, core 0 has run high and start PC equal to `RESET_VEC` (default 0x0000_1000). Cores 1 to 3 have run low and start PC zero. No start strobe is high.
- R2: A write to the parameter register (aux address 0x0A0) changes no run line, start PC or start strobe.
- R3: A command word with opcode 0x01 (load-PC) in bits 7:0 and a core index in bits 31:8 copies the current parameter value into the start PC of that core, provided the core is halted. Every other core is left unchanged, and the targeted core stays halted.
- R4: A command word with opcode 0x02 (release) for a halted core whose PC has been loaded raises that core's run line and its start strobe on the first clock edge after the write. The strobe falls on the next edge.
- R5: Once a core's run line is high, it stays high until reset.
- R6: A release command for a core that has not received a load-PC command since reset is ignored. Load-PC must come first.
- R7: A command whose index field (bits 31:8) is 4 or more is ignored and changes no state.
- R8: A command whose opcode is neither 0x01 nor 0x02 is ignored and changes no state.
- R9: A load-PC or release command aimed at a core that is already running is ignored. Its start PC is not reloaded and no strobe is issued.
- R10: Writes with the write enable low, or to an address other than 0x0A0 (parameter) or 0x0A1 (command), are ignored.
- R11: A start PC keeps the value captured by its load-PC command when the parameter register is written again later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_we | input | 1 | Auxiliary register write enable |
| aux_addr | input | 12 | Auxiliary register address |
| aux_wdata | input | 32 | Auxiliary register write data |
| core_pc | output | 128 | Start PC per core, core c in bits 32c+31:32c |
| core_run | output | 4 | Run (1) or halt (0) per core |
| core_start | output | 4 | One-cycle start strobe per core |

## Verification
Every result is due exactly one clock edge after the write that causes it. A parameter write, a PC load, or a run/strobe rise is visible after the edge that samples the write, and the strobe is gone after the following edge. The bench drives each write on a falling edge. It compares all outputs against its model on the next falling edge, after exactly one rising edge, and then checks again one idle edge later to confirm that the strobe has fallen. Sweeps cover all opcodes of interest against indices 0 to 5, in the order halted-unloaded, loaded and running, so each ignore rule is seen at the ports.

// File: rtl/core_start_pkg.sv
package core_start_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned OP_W    = 8;
    localparam int unsigned IDX_LSB = OP_W;
    localparam int unsigned IDX_W   = WORD_W - IDX_LSB;

    localparam logic [OP_W-1:0] OPC_LOAD_PC = 8'h01;
    localparam logic [OP_W-1:0] OPC_RELEASE = 8'h02;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_LOAD_PC = 2'd1,
        CMD_RELEASE = 2'd2
    } cs_kind_e;

    typedef struct packed {
        cs_kind_e           kind;
        logic [IDX_W-1:0]   idx;
    } cs_cmd_t;

    function automatic cs_cmd_t cs_decode(input logic [WORD_W-1:0] word);
        cs_cmd_t c;
        c.idx = word[WORD_W-1:IDX_LSB];
        case (word[OP_W-1:0])
            OPC_LOAD_PC: c.kind = CMD_LOAD_PC;
            OPC_RELEASE: c.kind = CMD_RELEASE;
            default:     c.kind = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cst_aux_decode.sv
module cst_aux_decode
    import core_start_pkg::*;
#(
    parameter int unsigned          NUM_CORES  = 4,
    parameter int unsigned          AUX_ADDR_W = 12,
    parameter logic [AUX_ADDR_W-1:0] PARAM_ADDR = 12'h0A0,
    parameter logic [AUX_ADDR_W-1:0] CMD_ADDR   = 12'h0A1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  aux_we,
    input  logic [AUX_ADDR_W-1:0] aux_addr,
    input  logic [WORD_W-1:0]     aux_wdata,
    output logic [WORD_W-1:0]     param_q,
    output logic [NUM_CORES-1:0]  sel_load,
    output logic [NUM_CORES-1:0]  sel_release
);

    logic    param_wr;
    logic    cmd_wr;
    cs_cmd_t cmd;

    assign param_wr = aux_we && (aux_addr == PARAM_ADDR);
    assign cmd_wr   = aux_we && (aux_addr == CMD_ADDR);
    assign cmd      = cs_decode(aux_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            param_q <= '0;
        end else if (param_wr) begin
            param_q <= aux_wdata;
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
        logic hit;
        assign hit            = cmd_wr && (cmd.idx == IDX_W'(c));
        assign sel_load[c]    = hit && (cmd.kind == CMD_LOAD_PC);
        assign sel_release[c] = hit && (cmd.kind == CMD_RELEASE);
    end

endmodule

// File: rtl/cst_core_slot.sv
module cst_core_slot
    import core_start_pkg::*;
#(
    parameter bit                BOOT      = 1'b0,
    parameter logic [WORD_W-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              release_req,
    input  logic [WORD_W-1:0] param,
    output logic [WORD_W-1:0] pc,
    output logic              run,
    output logic              start
);

    localparam logic [WORD_W-1:0] PC_INIT = BOOT ? RESET_VEC : '0;

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= PC_INIT;
            run   <= BOOT;
            armed <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (!run) begin
                if (load) begin
                    pc    <= param;
                    armed <= 1'b1;
                end else if (release_req && armed) begin
                    run   <= 1'b1;
                    start <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/core_start_ctrl.sv
module core_start_ctrl
    import core_start_pkg::*;
#(
    parameter int unsigned          NUM_CORES  = 4,
    parameter int unsigned          AUX_ADDR_W = 12,
    parameter logic [AUX_ADDR_W-1:0] PARAM_ADDR = 12'h0A0,
    parameter logic [AUX_ADDR_W-1:0] CMD_ADDR   = 12'h0A1,
    parameter logic [WORD_W-1:0]    RESET_VEC  = 32'h0000_1000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        aux_we,
    input  logic [AUX_ADDR_W-1:0]       aux_addr,
    input  logic [WORD_W-1:0]           aux_wdata,
    output logic [NUM_CORES*WORD_W-1:0] core_pc,
    output logic [NUM_CORES-1:0]        core_run,
    output logic [NUM_CORES-1:0]        core_start
);

    logic [WORD_W-1:0]    param_q;
    logic [NUM_CORES-1:0] sel_load;
    logic [NUM_CORES-1:0] sel_release;

    cst_aux_decode #(
        .NUM_CORES  (NUM_CORES),
        .AUX_ADDR_W (AUX_ADDR_W),
        .PARAM_ADDR (PARAM_ADDR),
        .CMD_ADDR   (CMD_ADDR)
    ) u_dec (
        .clk         (clk),
        .rst         (rst),
        .aux_we      (aux_we),
        .aux_addr    (aux_addr),
        .aux_wdata   (aux_wdata),
        .param_q     (param_q),
        .sel_load    (sel_load),
        .sel_release (sel_release)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        cst_core_slot #(
            .BOOT      (c == 0),
            .RESET_VEC (RESET_VEC)
        ) u_slot (
            .clk         (clk),
            .rst         (rst),
            .load        (sel_load[c]),
            .release_req (sel_release[c]),
            .param       (param_q),
            .pc          (core_pc[c*WORD_W +: WORD_W]),
            .run         (core_run[c]),
            .start       (core_start[c])
        );
    end

endmodule

// File: rtl/core_start_ctrl_sva.sv
module core_start_ctrl_sva #(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned WORD_W    = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_CORES*WORD_W-1:0] core_pc,
    input logic [NUM_CORES-1:0]        core_run,
    input logic [NUM_CORES-1:0]        core_start
);

    // R1: the boot core is running in every cycle out of reset
    a_r1_boot_runs: assert property (@(posedge clk) disable iff (rst)
        core_run[0]);

    // R4: one command per write, so at most one strobe at a time
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_start));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        // R4: strobe lasts one cycle
        a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
            core_start[c] |=> !core_start[c]);

        // R4: strobe only on the cycle run rises
        a_r4_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
            core_start[c] |-> (core_run[c] && !$past(core_run[c])));

        // R5: run is sticky
        a_r5_run_sticky: assert property (@(posedge clk) disable iff (rst)
            core_run[c] |=> core_run[c]);

        // R9: a running core's start PC never changes
        a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
            core_run[c] |=> $stable(core_pc[c*WORD_W +: WORD_W]));
    end

endmodule

bind core_start_ctrl core_start_ctrl_sva #(
    .NUM_CORES (NUM_CORES),
    .WORD_W    (core_start_pkg::WORD_W)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .core_pc    (core_pc),
    .core_run   (core_run),
    .core_start (core_start)
);

// File: tb/core_start_ctrl_bench.sv
module core_start_ctrl_bench;

    localparam int NC = 4;
    localparam logic [11:0] A_PARAM = 12'h0A0;
    localparam logic [11:0] A_CMD   = 12'h0A1;
    localparam logic [31:0] RVEC    = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          aux_we = 1'b0;
    logic [11:0]   aux_addr = '0;
    logic [31:0]   aux_wdata = '0;
    logic [NC*32-1:0] core_pc;
    logic [NC-1:0] core_run;
    logic [NC-1:0] core_start;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0]   m_param;
    logic [31:0]   m_pc [NC];
    logic [NC-1:0] m_run;
    logic [NC-1:0] m_loaded;
    logic [NC-1:0] m_start;

    always #10 clk = ~clk;

    core_start_ctrl u_core_start_ctrl (
        .clk        (clk),
        .rst        (rst),
        .aux_we     (aux_we),
        .aux_addr   (aux_addr),
        .aux_wdata  (aux_wdata),
        .core_pc    (core_pc),
        .core_run   (core_run),
        .core_start (core_start)
    );

    task automatic check(input string tag);
        logic [NC*32-1:0] epc;
        for (int c = 0; c < NC; c++) epc[c*32 +: 32] = m_pc[c];
        n_tests++;
        if (core_run !== m_run || core_start !== m_start || core_pc !== epc) begin
            n_fail++;
            $display("FAIL %s: run=%b exp %b start=%b exp %b pc=%h exp %h",
                     tag, core_run, m_run, core_start, m_start, core_pc, epc);
        end
    endtask

    // model update from the requirements
    task automatic model(input logic we, input logic [11:0] a, input logic [31:0] d);
        int unsigned idx;
        m_start = '0;
        if (we && a == A_PARAM) m_param = d;
        if (we && a == A_CMD) begin
            idx = d[31:8];
            if (idx < NC && !m_run[idx]) begin
                if (d[7:0] == 8'h01) begin
                    m_pc[idx]     = m_param;
                    m_loaded[idx] = 1'b1;
                end else if (d[7:0] == 8'h02 && m_loaded[idx]) begin
                    m_run[idx]   = 1'b1;
                    m_start[idx] = 1'b1;
                end
            end
        end
    endtask

    // drive on falling edge, result due after one rising edge
    task automatic wr(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input string tag);
        @(negedge clk);
        aux_we = we; aux_addr = a; aux_wdata = d;
        @(negedge clk);
        aux_we = 1'b0;
        model(we, a, d);
        check(tag);
        @(negedge clk);
        m_start = '0;
        check({tag, " strobe-fall"});
    endtask

    function automatic logic [31:0] cmdw(input int idx, input logic [7:0] op);
        return {24'(idx), op};
    endfunction

    initial begin
        m_param = '0; m_run = 4'b0001; m_loaded = '0; m_start = '0;
        m_pc[0] = RVEC;
        for (int c = 1; c < NC; c++) m_pc[c] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset");

        wr(1'b1, A_PARAM, 32'hCAFE_0100, "R2 param write");

        // R6 / R7 / R8: sweep before any load; nothing may change
        foreach (m_run[i]) ; 
        for (int idx = 0; idx < 6; idx++) begin
            wr(1'b1, A_CMD, cmdw(idx, 8'h02), "R6 release unloaded");
            wr(1'b1, A_CMD, cmdw(idx, 8'h00), "R8 opcode 0x00");
            wr(1'b1, A_CMD, cmdw(idx, 8'h03), "R8 opcode 0x03");
            wr(1'b1, A_CMD, cmdw(idx, 8'h81), "R8 opcode 0x81");
        end

        // R10: wrong address and write-enable low
        wr(1'b1, 12'h0A2, cmdw(1, 8'h01), "R10 other address");
        wr(1'b0, A_CMD, cmdw(1, 8'h01), "R10 we low cmd");
        wr(1'b0, A_PARAM, 32'h1111_1111, "R10 we low param");

        // R3 / R7 / R9: load-PC sweep with distinct addresses
        for (int idx = 0; idx < 6; idx++) begin
            wr(1'b1, A_PARAM, 32'h2000_0000 + 32'(idx) * 32'h40, "R2 param");
            wr(1'b1, A_CMD, cmdw(idx, 8'h01),
               idx == 0 ? "R9 load running core" : (idx >= NC ? "R7 bad index" : "R3 load"));
        end

        // R11: later param write keeps latched PCs
        wr(1'b1, A_PARAM, 32'hDEAD_BEEF, "R11 param after load");
        // reload core 2 with a new value while halted
        wr(1'b1, A_CMD, cmdw(2, 8'h01), "R3 reload halted");

        // R4 / R7: release sweep
        for (int idx = 1; idx < 6; idx++)
            wr(1'b1, A_CMD, cmdw(idx, 8'h02), idx >= NC ? "R7 bad index" : "R4 release");

        // R9 / R5: commands to running cores
        wr(1'b1, A_PARAM, 32'h0BAD_0BAD, "R2 param");
        for (int idx = 0; idx < NC; idx++) begin
            wr(1'b1, A_CMD, cmdw(idx, 8'h01), "R9 load running");
            wr(1'b1, A_CMD, cmdw(idx, 8'h02), "R9 release running");
        end
        repeat (5) @(negedge clk);
        check("R5 run sticky");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run=%b exp done", core_run);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule